// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block lets peripherals signal interrupts by writing to it over a bus instead of driving a dedicated wire. A peripheral sends a "raise" message: a write whose address names its source slot and whose data word is a payload. The aggregator marks that source pending, keeps the payload, and drives one interrupt line to the processor. The processor services the peripheral directly. The peripheral then sends a "clear" message for the same slot. The line drops once no source is pending.

Messages arrive on several independent write lanes, so writes from different masters can be issued back to back and in parallel. Each lane accepts one write per cycle with no wait states. A separate read port lets the processor read the pending bitmap and the payload stored for any source.

Top module: `msg_irq_agg`

## Requirements
- R1: After reset, no source is pending, the interrupt line is low, no acknowledge is asserted, and every stored payload reads as zero.
- R2: A lane write whose address has bits [7:6]=00, bits [5:4]=00 and bits [3:0]=s marks source s pending. The interrupt line is high in the cycle after that write.
- R3: A lane write with bits [7:6]=01, bits [5:4]=00 and bits [3:0]=s clears source s. The line is low in the next cycle if no other source is pending, and stays high otherwise.
- R4: A raise write stores its data word as the payload of source s. A read of address 0x80|s returns the most recent such word.
- R5: A read of address 0xC0 returns the pending bitmap, with bit s set for pending source s and all upper bits zero.
- R6: If one lane raises source s and another lane clears s in the same cycle, s ends up pending.
- R7: If two lanes raise the same source in the same cycle, the lower-numbered lane's data becomes the payload.
- R8: Every lane strobe is acknowledged on that lane exactly one cycle later, as a one-cycle pulse for each strobed cycle, including back-to-back strobes.
- R9: Lane writes to addresses in the 0x80 or 0xC0 regions, or with bits [5:4] non-zero, are acknowledged and change neither pending state, payloads nor the interrupt line.
- R10: A read strobe is answered one cycle later with the read acknowledge. A read of any address that maps to nothing (for example 0xC1, or 0x90) returns zero.
- R11: The interrupt line is always the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_stb | input | LANES | Per-lane write strobe, one message per strobed cycle |
| msg_addr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low slice |
| msg_wdata | input | LANES*DATA_W | Per-lane write data (payload) |
| msg_ack | output | LANES | Per-lane acknowledge, one cycle after the strobe |
| rd_stb | input | 1 | Processor read strobe |
| rd_addr | input | ADDR_W | Processor read address |
| rd_data | output | DATA_W | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read acknowledge, one cycle after rd_stb |
| irq | output | 1 | Aggregated interrupt line to the processor |

## Verification
All results are registered, so every result of a message is due in the cycle after its strobe. This covers the lane acknowledge, the change in pending state and the interrupt line. A read reflects the state at the strobe cycle and returns its data and acknowledge one cycle later. The bench drives inputs on falling edges, waits exactly one falling edge after each strobe and samples there. Back-to-back and two-lane cases are checked cycle by cycle in that same way.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

  // Top two address bits pick the function of an access.
  typedef enum logic [1:0] {
    RGN_RAISE   = 2'b00,
    RGN_CLEAR   = 2'b01,
    RGN_PAYLOAD = 2'b10,
    RGN_STATUS  = 2'b11
  } rgn_e;

endpackage

// File: rtl/msg_irq_lane_dec.sv
module msg_irq_lane_dec
  import msg_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SRC-1:0] raise_vec,
  output logic [NUM_SRC-1:0] clear_vec,
  output logic               pay_we,
  output logic [SRC_W-1:0]   pay_idx,
  output logic               ack
);

  rgn_e             rgn;
  logic [SRC_W-1:0] idx;
  logic             guard_ok;
  logic             idx_ok;
  logic             hit;

  assign rgn      = rgn_e'(addr[ADDR_W-1 -: 2]);
  assign idx      = addr[SRC_W-1:0];
  assign guard_ok = (addr[ADDR_W-3:SRC_W] == '0);
  assign idx_ok   = guard_ok && (32'(idx) < NUM_SRC);
  assign hit      = stb && idx_ok;

  always_comb begin
    raise_vec = '0;
    clear_vec = '0;
    if (hit && (rgn == RGN_RAISE)) raise_vec[idx] = 1'b1;
    if (hit && (rgn == RGN_CLEAR)) clear_vec[idx] = 1'b1;
  end

  assign pay_we  = hit && (rgn == RGN_RAISE);
  assign pay_idx = idx;

  // Zero-wait acknowledge: every strobed cycle answered next cycle.
  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= stb;
  end

endmodule

// File: rtl/msg_irq_pend.sv
module msg_irq_pend #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pending,
  output logic               irq
);

  logic [NUM_SRC-1:0] pend_nxt;

  // Set terms are applied after clear terms: a raise wins.
  assign pend_nxt = (pending & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      irq     <= 1'b0;
    end else begin
      pending <= pend_nxt;
      irq     <= |pend_nxt;
    end
  end

endmodule

// File: rtl/msg_irq_payload.sv
module msg_irq_payload #(
  parameter int NUM_SRC = 16,
  parameter int LANES   = 2,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*SRC_W-1:0]  widx,
  input  logic [LANES*DATA_W-1:0] wdata,
  input  logic [SRC_W-1:0]        ridx,
  output logic [DATA_W-1:0]       rdata
);

  logic [DATA_W-1:0] mem [NUM_SRC];

  // Lanes are visited from highest to lowest; the last nonblocking
  // assignment to a slot takes effect, so lane 0 has top priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) mem[s] <= '0;
    end else begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (we[l]) mem[widx[l*SRC_W +: SRC_W]] <= wdata[l*DATA_W +: DATA_W];
      end
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/msg_irq_rdport.sv
module msg_irq_rdport
  import msg_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_stb,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [DATA_W-1:0]  pay_rdata,
  output logic [SRC_W-1:0]   pay_ridx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_ack
);

  rgn_e              rgn;
  logic              guard_ok;
  logic              idx_ok;
  logic              status_hit;
  logic [DATA_W-1:0] sel;

  assign rgn        = rgn_e'(rd_addr[ADDR_W-1 -: 2]);
  assign pay_ridx   = rd_addr[SRC_W-1:0];
  assign guard_ok   = (rd_addr[ADDR_W-3:SRC_W] == '0);
  assign idx_ok     = guard_ok && (32'(pay_ridx) < NUM_SRC);
  assign status_hit = (rgn == RGN_STATUS) && (rd_addr[ADDR_W-3:0] == '0);

  always_comb begin
    sel = '0;
    if (status_hit)                        sel = DATA_W'(pending);
    else if ((rgn == RGN_PAYLOAD) && idx_ok) sel = pay_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= rd_stb;
      if (rd_stb) rd_data <= sel;
    end
  end

endmodule

// File: rtl/msg_irq_agg.sv
module msg_irq_agg #(
  parameter int NUM_SRC = 16,
  parameter int LANES   = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        msg_stb,
  input  logic [LANES*ADDR_W-1:0] msg_addr,
  input  logic [LANES*DATA_W-1:0] msg_wdata,
  output logic [LANES-1:0]        msg_ack,
  input  logic                    rd_stb,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_ack,
  output logic                    irq
);

  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]     lane_raise [LANES];
  logic [NUM_SRC-1:0]     lane_clear [LANES];
  logic [LANES-1:0]       pay_we;
  logic [LANES*SRC_W-1:0] pay_widx;
  logic [NUM_SRC-1:0]     set_all;
  logic [NUM_SRC-1:0]     clr_all;
  logic [NUM_SRC-1:0]     pending;
  logic [SRC_W-1:0]       pay_ridx;
  logic [DATA_W-1:0]      pay_rdata;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    msg_irq_lane_dec #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W)
    ) u_dec (
      .clk       (clk),
      .rst       (rst),
      .stb       (msg_stb[g]),
      .addr      (msg_addr[g*ADDR_W +: ADDR_W]),
      .raise_vec (lane_raise[g]),
      .clear_vec (lane_clear[g]),
      .pay_we    (pay_we[g]),
      .pay_idx   (pay_widx[g*SRC_W +: SRC_W]),
      .ack       (msg_ack[g])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int l = 0; l < LANES; l++) begin
      set_all = set_all | lane_raise[l];
      clr_all = clr_all | lane_clear[l];
    end
  end

  msg_irq_pend #(
    .NUM_SRC (NUM_SRC)
  ) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_all),
    .clr_vec (clr_all),
    .pending (pending),
    .irq     (irq)
  );

  msg_irq_payload #(
    .NUM_SRC (NUM_SRC),
    .LANES   (LANES),
    .DATA_W  (DATA_W)
  ) u_pay (
    .clk   (clk),
    .rst   (rst),
    .we    (pay_we),
    .widx  (pay_widx),
    .wdata (msg_wdata),
    .ridx  (pay_ridx),
    .rdata (pay_rdata)
  );

  msg_irq_rdport #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .pending   (pending),
    .pay_rdata (pay_rdata),
    .pay_ridx  (pay_ridx),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack)
  );

endmodule

// File: rtl/msg_irq_agg_chk.sv
module msg_irq_agg_chk #(
  parameter int NUM_SRC = 16,
  parameter int LANES   = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        msg_stb,
  input logic [LANES*ADDR_W-1:0] msg_addr,
  input logic [LANES-1:0]        msg_ack,
  input logic                    rd_stb,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [DATA_W-1:0]       rd_data,
  input logic                    rd_ack,
  input logic                    irq
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};

  logic any_raise;

  always_comb begin
    any_raise = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (msg_stb[l]
          && (msg_addr[l*ADDR_W + ADDR_W - 1 -: 2] == 2'b00)
          && (msg_addr[l*ADDR_W + SRC_W +: (ADDR_W-2-SRC_W)] == '0)
          && (32'(msg_addr[l*ADDR_W +: SRC_W]) < NUM_SRC))
        any_raise = 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R8
    a_r8_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
      msg_stb[g] |=> msg_ack[g]);
    // R8
    a_r8_no_unasked_ack: assert property (@(posedge clk) disable iff (rst)
      !msg_stb[g] |=> !msg_ack[g]);
  end

  a_r10_rd_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_ack);

  a_r10_no_unasked_rd_ack: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_ack);

  a_r2_raise_drives_irq: assert property (@(posedge clk) disable iff (rst)
    any_raise |=> irq);

  a_r3_quiet_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (msg_stb == '0) |=> $stable(irq));

  a_r11_irq_matches_status: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && ($past(rd_addr) == STATUS_ADDR)) |-> ((rd_data != '0) == $past(irq)));

endmodule

bind msg_irq_agg msg_irq_agg_chk #(
  .NUM_SRC (NUM_SRC),
  .LANES   (LANES),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .msg_stb  (msg_stb),
  .msg_addr (msg_addr),
  .msg_ack  (msg_ack),
  .rd_stb   (rd_stb),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .rd_ack   (rd_ack),
  .irq      (irq)
);

// File: tb/msg_irq_agg_bench.sv
module msg_irq_agg_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  msg_stb;
  logic [15:0] msg_addr;
  logic [63:0] msg_wdata;
  logic [1:0]  msg_ack;
  logic        rd_stb;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_ack;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  msg_irq_agg u_msg_irq_agg (
    .clk       (clk),
    .rst       (rst),
    .msg_stb   (msg_stb),
    .msg_addr  (msg_addr),
    .msg_wdata (msg_wdata),
    .msg_ack   (msg_ack),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed cycle on the selected lanes; returns at the sampling edge.
  task automatic send(input logic [1:0] m, input logic [7:0] a0, input logic [31:0] d0,
                      input logic [7:0] a1, input logic [31:0] d1);
    @(negedge clk);
    msg_stb   = m;
    msg_addr  = {a1, a0};
    msg_wdata = {d1, d0};
    @(negedge clk);
    msg_stb = 2'b00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    rd_stb  = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
    d   = rd_data;
    ack = rd_ack;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic a;
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 acks after reset", 32'(msg_ack), 0);
    rd(8'hC0, d, a);
    check("R1 pending after reset", d, 0);
    check("R10 read ack", 32'(a), 1);
    rd(8'h85, d, a);
    check("R1 payload after reset", d, 0);
  endtask

  task automatic t_raise_clear();
    logic [31:0] d; logic a;
    send(2'b01, 8'h03, 32'hCAFE_0003, 8'h00, 0);
    check("R8 ack of raise", 32'(msg_ack), 32'h1);
    check("R2 irq after raise", 32'(irq), 1);
    @(negedge clk);
    check("R8 ack is one pulse", 32'(msg_ack), 0);
    rd(8'hC0, d, a);
    check("R5 pending map", d, 32'h0000_0008);
    rd(8'h83, d, a);
    check("R4 payload of source 3", d, 32'hCAFE_0003);
    send(2'b01, 8'h43, 0, 8'h00, 0);
    check("R3 irq drops after clear", 32'(irq), 0);
    rd(8'hC0, d, a);
    check("R11 status empty with irq low", d, 0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] d; logic a;
    @(negedge clk);
    msg_stb = 2'b01; msg_addr = {8'h00, 8'h01}; msg_wdata = {32'h0, 32'h1111_0001};
    @(negedge clk);
    check("R8 ack of first in burst", 32'(msg_ack), 32'h1);
    msg_addr = {8'h00, 8'h0E}; msg_wdata = {32'h0, 32'h1111_000E};
    @(negedge clk);
    msg_stb = 2'b00;
    check("R8 ack of second in burst", 32'(msg_ack), 32'h1);
    @(negedge clk);
    check("R8 ack ends after burst", 32'(msg_ack), 0);
    rd(8'hC0, d, a);
    check("R5 two sources pending", d, 32'h0000_4002);
    send(2'b10, 8'h00, 0, 8'h41, 0);
    check("R8 lane 1 ack", 32'(msg_ack), 32'h2);
    check("R3 irq held by other source", 32'(irq), 1);
    rd(8'hC0, d, a);
    check("R11 status nonzero with irq high", 32'(d != 0), 32'(irq));
    send(2'b01, 8'h4E, 0, 8'h00, 0);
    check("R3 irq low after last clear", 32'(irq), 0);
  endtask

  task automatic t_overwrite();
    logic [31:0] d; logic a;
    send(2'b01, 8'h07, 32'hAAAA_0007, 8'h00, 0);
    send(2'b10, 8'h00, 0, 8'h07, 32'hBBBB_0007);
    rd(8'h87, d, a);
    check("R4 later payload replaces earlier", d, 32'hBBBB_0007);
    send(2'b01, 8'h47, 0, 8'h00, 0);
    check("R3 irq low after clear of 7", 32'(irq), 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d; logic a;
    send(2'b11, 8'h09, 32'h9999_0009, 8'h49, 0);
    check("R6 raise wins over clear (irq)", 32'(irq), 1);
    rd(8'hC0, d, a);
    check("R6 raise wins over clear (map)", d, 32'h0000_0200);
    send(2'b11, 8'h49, 0, 8'h09, 32'h9999_1009);
    rd(8'hC0, d, a);
    check("R6 raise on lane 1 wins too", d, 32'h0000_0200);
    send(2'b11, 8'h02, 32'h0000_0AAA, 8'h02, 32'h0000_0BBB);
    check("R8 both lanes acked", 32'(msg_ack), 32'h3);
    rd(8'h82, d, a);
    check("R7 lane 0 payload kept", d, 32'h0000_0AAA);
    send(2'b11, 8'h49, 0, 8'h42, 0);
    check("R3 irq low after both cleared", 32'(irq), 0);
  endtask

  task automatic t_unused();
    logic [31:0] d; logic a;
    send(2'b01, 8'h05, 32'h5555_0005, 8'h00, 0);
    send(2'b11, 8'h85, 32'hDEAD_0001, 8'hC0, 32'hDEAD_0002);
    check("R9 unused writes acked", 32'(msg_ack), 32'h3);
    send(2'b11, 8'h15, 32'hDEAD_0003, 8'h55, 32'hDEAD_0004);
    check("R9 guard-bit writes acked", 32'(msg_ack), 32'h3);
    check("R9 irq unchanged", 32'(irq), 1);
    rd(8'hC0, d, a);
    check("R9 pending unchanged", d, 32'h0000_0020);
    rd(8'h85, d, a);
    check("R9 payload unchanged", d, 32'h5555_0005);
    rd(8'hC1, d, a);
    check("R10 unused status offset reads zero", d, 0);
    rd(8'h95, d, a);
    check("R10 guard-bit read returns zero", d, 0);
    check("R10 read ack on unused address", 32'(a), 1);
    send(2'b01, 8'h45, 0, 8'h00, 0);
    check("R3 irq low at end", 32'(irq), 0);
  endtask

  initial begin
    rst = 1'b1; msg_stb = 0; msg_addr = 0; msg_wdata = 0; rd_stb = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raise_clear();
    t_back_to_back();
    t_overwrite();
    t_same_cycle();
    t_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule